// File: doc/BRIEF.md
# Channel Fault Flag Bank with Access Filtering

This block keeps one sticky flag per DMA channel, which records that the channel was used illegally. A flag is raised by a one-cycle event pulse from the channel logic, whatever security or privilege mode the channel is in. Software sees the flags through a small register port and clears them through a second register port. Every access on that port carries two attributes: secure and privileged.

Each channel has a secure-mode bit and a privileged-mode bit. These bits decide which accesses may see or clear that channel's flag. A channel is visible to an access when two conditions both hold: the access is privileged or the channel is not privileged, and the access is secure or the channel is not secure. A status read returns the flags of visible channels only. A clear write acts only on visible channels. Bits that are masked out read as zero, and clear bits that are not allowed are dropped one by one with no error. One interrupt line is driven high when any flag is set whose interrupt enable is on.

Top module: `chan_fault_flags`

## Requirements
- R1: After reset every flag is clear, `bus_rdata_o` is zero and `irq_o` is low.
- R2: An event pulse on a channel sets that channel's flag at the next clock edge, for any combination of the channel's secure and privileged mode bits.
- R3: A read of offset 0x100 returns, in the cycle after the request, flag i in bit i when the access can see channel i. It returns 0 in bit i when channel i is privileged and the access is not, or when channel i is secure and the access is not. Bits above the channel count read as zero.
- R4: A write to offset 0x104 with bit i set clears flag i at the next edge when the access can see channel i (same rule as R3).
- R5: A clear bit written as 0, or a clear bit for a channel the access cannot see, leaves that flag unchanged.
- R6: When an event and an allowed clear hit the same flag in the same cycle, the flag ends up set.
- R7: Writes to offset 0x100 or to any offset other than 0x104 leave the flags unchanged. Reads of any offset other than 0x100 return zero.
- R8: A read of the clear register at offset 0x104 returns zero.
- R9: `irq_o` is high in the same cycle as any flag i that is set while `irq_en_i[i]` is high, and low otherwise.
- R10: `bus_rdata_o` keeps its last value in cycles with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CH | Per-channel illegal-access event pulse |
| ch_secure_i | input | NUM_CH | Per-channel secure mode bit |
| ch_priv_i | input | NUM_CH | Per-channel privileged mode bit |
| irq_en_i | input | NUM_CH | Per-channel interrupt enable |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | NUM_CH | Clear mask, one bit per channel; the reserved upper bits are not carried |
| bus_sec_i | input | 1 | Access is secure |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt, any enabled flag set |

## Verification
Flag changes from events and clear writes take effect at the first clock edge after the stimulus. Read data is registered at the edge where the request is sampled. The interrupt follows the flags combinationally, so it moves in the same cycle as the flags. The bench drives every input on the falling edge. After the next rising edge it updates its model, and it compares read data and the interrupt at the following falling edge. A flag change is therefore checked through a read issued one cycle later, whose data is due one further edge on.

// File: rtl/cff_pkg.sv
package cff_pkg;

    // Decoded register access for one cycle
    typedef struct packed {
        logic stat_rd;   // read of the status register
        logic clr_rd;    // read of the clear register
        logic other_rd;  // read of any other offset
        logic clr_wr;    // write to the clear register
    } acc_dec_t;

endpackage

// File: rtl/cff_decode.sv
module cff_decode #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] STAT_OFS = 12'h100,
    parameter logic [11:0] CLR_OFS  = 12'h104
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cff_pkg::acc_dec_t dec_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

    logic hit_stat;
    logic hit_clr;

    always_comb begin
        hit_stat       = (addr_i == STAT_A);
        hit_clr        = (addr_i == CLR_A);
        dec_o.stat_rd  = req_i && !we_i && hit_stat;
        dec_o.clr_rd   = req_i && !we_i && hit_clr;
        dec_o.other_rd = req_i && !we_i && !hit_stat && !hit_clr;
        dec_o.clr_wr   = req_i &&  we_i && hit_clr;
    end
endmodule

// File: rtl/cff_perm.sv
module cff_perm #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] ch_secure_i,
    input  logic [NUM_CH-1:0] ch_priv_i,
    input  logic              acc_sec_i,
    input  logic              acc_priv_i,
    output logic [NUM_CH-1:0] allow_o
);
    // One visibility term per channel: the access must meet or exceed the
    // channel's level on both axes.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic priv_ok;
        logic sec_ok;
        always_comb begin
            priv_ok    = acc_priv_i || !ch_priv_i[g];
            sec_ok     = acc_sec_i  || !ch_secure_i[g];
            allow_o[g] = priv_ok && sec_ok;
        end
    end
endmodule

// File: rtl/cff_bank.sv
module cff_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              clr_wr_i,
    input  logic [NUM_CH-1:0] clr_mask_i,
    input  logic [NUM_CH-1:0] allow_i,
    output logic [NUM_CH-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_CH-1:0] clr_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = clr_wr_i ? (clr_mask_i & allow_i) : '0;
        // Clear first, then set: an event in the same cycle survives
        st_d.flags = (st_q.flags & ~clr_hit) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/cff_rdport.sv
module cff_rdport #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cff_pkg::acc_dec_t dec_i,
    input  logic [NUM_CH-1:0] flags_i,
    input  logic [NUM_CH-1:0] allow_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - NUM_CH;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dec_i.stat_rd)
            st_d.rdata = {{PAD_W{1'b0}}, flags_i & allow_i};
        else if (dec_i.clr_rd || dec_i.other_rd)
            st_d.rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/chan_fault_flags.sv
module chan_fault_flags #(
    parameter int          NUM_CH   = 8,
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] STAT_OFS = 12'h100,
    parameter logic [11:0] CLR_OFS  = 12'h104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic [NUM_CH-1:0] ch_secure_i,
    input  logic [NUM_CH-1:0] ch_priv_i,
    input  logic [NUM_CH-1:0] irq_en_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NUM_CH-1:0] bus_wdata_i,
    input  logic              bus_sec_i,
    input  logic              bus_priv_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    cff_pkg::acc_dec_t dec;
    logic [NUM_CH-1:0] allow;
    logic [NUM_CH-1:0] flags_q;

    cff_decode #(
        .ADDR_W  (ADDR_W),
        .STAT_OFS(STAT_OFS),
        .CLR_OFS (CLR_OFS)
    ) u_decode (
        .req_i (bus_req_i),
        .we_i  (bus_we_i),
        .addr_i(bus_addr_i),
        .dec_o (dec)
    );

    cff_perm #(.NUM_CH(NUM_CH)) u_perm (
        .ch_secure_i(ch_secure_i),
        .ch_priv_i  (ch_priv_i),
        .acc_sec_i  (bus_sec_i),
        .acc_priv_i (bus_priv_i),
        .allow_o    (allow)
    );

    cff_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_wr_i  (dec.clr_wr),
        .clr_mask_i(bus_wdata_i),
        .allow_i   (allow),
        .flags_o   (flags_q)
    );

    cff_rdport #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdport (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_i  (dec),
        .flags_i(flags_q),
        .allow_i(allow),
        .rdata_o(bus_rdata_o)
    );

    assign irq_o = |(flags_q & irq_en_i);
endmodule

// File: rtl/cff_checker.sv
module cff_checker #(
    parameter int          NUM_CH   = 8,
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] CLR_OFS  = 12'h104
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] evt_i,
    input logic [NUM_CH-1:0] ch_secure_i,
    input logic [NUM_CH-1:0] ch_priv_i,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [NUM_CH-1:0] bus_wdata_i,
    input logic              bus_sec_i,
    input logic              bus_priv_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              irq_o,
    input logic [NUM_CH-1:0] flags_q
);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic clr_wr_seen;
    logic clr_rd_seen;
    assign clr_wr_seen = bus_req_i && bus_we_i && (bus_addr_i == CLR_A);
    assign clr_rd_seen = bus_req_i && !bus_we_i && (bus_addr_i == CLR_A);

    // R3: reserved upper bits never carry data
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[DATA_W-1:NUM_CH] == '0);

    // R8: clear register reads back as zero
    a_r8_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd_seen |=> bus_rdata_o == '0);

    // R9: interrupt only with some flag up
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_q != '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ok;
        assign ok = (bus_priv_i || !ch_priv_i[g]) && (bus_sec_i || !ch_secure_i[g]);

        // R2 and R6: an event always leaves the flag set
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flags_q[g]);

        // R4: an allowed clear with no event drops the flag
        a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_seen && bus_wdata_i[g] && ok && !evt_i[g]) |=> !flags_q[g]);

        // R5: a flag falls only after an allowed clear of that bit
        a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[g]) |-> $past(clr_wr_seen && bus_wdata_i[g] && ok));
    end
endmodule

bind chan_fault_flags cff_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CLR_OFS(CLR_OFS)
) u_cff_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .ch_secure_i(ch_secure_i),
    .ch_priv_i  (ch_priv_i),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_sec_i  (bus_sec_i),
    .bus_priv_i (bus_priv_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .flags_q    (flags_q)
);

// File: tb/chan_fault_flags_bench.sv
module chan_fault_flags_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam logic [AW-1:0] A_STAT = 12'h100;
    localparam logic [AW-1:0] A_CLR  = 12'h104;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] evt = '0, chs = '0, chp = '0, en = '0, wdata = '0;
    logic req = 1'b0, we = 1'b0, asec = 1'b0, apriv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] rdata;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NCH-1:0] m_flags = '0;
    logic [DW-1:0]  m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_fault_flags u_chan_fault_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ch_secure_i(chs), .ch_priv_i(chp),
        .irq_en_i(en), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_sec_i(asec), .bus_priv_i(apriv),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [NCH-1:0] vis(input logic s, input logic p,
                                           input logic [NCH-1:0] cs, input logic [NCH-1:0] cp);
        return (cp & {NCH{~p}} | cs & {NCH{~s}}) ^ {NCH{1'b1}};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        evt = '0; req = 1'b0; we = 1'b0; wdata = '0; addr = '0;
    endtask

    // Apply current inputs for one clock, advance the model, check at the next falling edge
    task automatic step(input string tag);
        logic [NCH-1:0] mask;
        mask = vis(asec, apriv, chs, chp);
        if (req && !we) m_rd = (addr == A_STAT) ? DW'(m_flags & mask) : '0;
        if (req && we && addr == A_CLR) m_flags = m_flags & ~(wdata & mask);
        m_flags = m_flags | evt;
        @(posedge clk);
        @(negedge clk);
        check(tag, rdata, m_rd);
        check({tag, " R9"}, DW'(irq), DW'(|(m_flags & en)));
        idle();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic s, input logic p, input string tag);
        req = 1'b1; we = 1'b0; addr = a; asec = s; apriv = p;
        step(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NCH-1:0] d,
                      input logic s, input logic p, input string tag);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; asec = s; apriv = p;
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, '0);
        check("R1 irq", DW'(irq), '0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_STAT, 1, 1, "R1");

        // R2: events set flags in every mode mix
        chs = 8'hF0; chp = 8'hCC; en = 8'hFF;
        evt = 8'hA5; step("R2");
        rd(A_STAT, 1, 1, "R2");
        evt = 8'h5A; step("R2");
        rd(A_STAT, 1, 1, "R2");

        // R3: filtered reads
        rd(A_STAT, 0, 0, "R3");
        rd(A_STAT, 1, 0, "R3");
        rd(A_STAT, 0, 1, "R3");

        // R10: no request holds rdata
        step("R10");

        // R5: disallowed and zero bits untouched
        wr(A_CLR, 8'hFF, 0, 0, "R5");
        rd(A_STAT, 1, 1, "R5");
        wr(A_CLR, 8'h00, 1, 1, "R5");
        rd(A_STAT, 1, 1, "R5");

        // R4: allowed clear
        wr(A_CLR, 8'h01, 1, 1, "R4");
        rd(A_STAT, 1, 1, "R4");

        // R6: set beats clear
        evt = 8'h02; req = 1'b1; we = 1'b1; addr = A_CLR; wdata = 8'h02; asec = 1; apriv = 1;
        step("R6");
        rd(A_STAT, 1, 1, "R6");

        // R7: writes elsewhere ignored, other reads zero
        wr(A_STAT, 8'hFF, 1, 1, "R7");
        wr(12'h108, 8'hFF, 1, 1, "R7");
        rd(A_STAT, 1, 1, "R7");
        rd(12'h108, 1, 1, "R7");

        // R8: clear register reads zero
        rd(A_CLR, 1, 1, "R8");

        // Random mix covering R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                chs = NCH'($urandom); chp = NCH'($urandom); en = NCH'($urandom);
            end
            evt   = ($urandom_range(0, 3) == 0) ? NCH'($urandom) & NCH'($urandom) : '0;
            req   = $urandom_range(0, 1) == 1;
            we    = $urandom_range(0, 1) == 1;
            case ($urandom_range(0, 3))
                0: addr = A_STAT;
                1: addr = A_CLR;
                2: addr = A_CLR;
                default: addr = AW'($urandom);
            endcase
            wdata = NCH'($urandom);
            asec  = $urandom_range(0, 1) == 1;
            apriv = $urandom_range(0, 1) == 1;
            step("RND R3 R4 R5");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule